// File: doc/BRIEF.md
# Dual-Edge Delay Tuning Sequencer

This block runs a sampling-delay search for a storage-card host interface. On a start pulse it tests the command line first and then the data lines. For each line it sweeps every pad delay tap with the rising sample edge, then sweeps them all again with the falling sample edge. Each tap gets one test request, and the block waits for a pass or fail reply. The replies build one pass map per edge. The test transaction itself belongs to a neighbouring block, which is reached through a simple request/response handshake.

When a line's two sweeps are complete, a window selector looks for the best run of passing taps in each map. It then picks one edge and one delay tap and drives them onto the edge and delay outputs for that line. If the command line has no passing tap at all, the data sweep is skipped. A one-cycle done pulse carries a two-bit status.

Top module: `tune_seq`

## Requirements
- R1: After an accepted start, the command stage (`test_is_data`=0) runs first and the data stage (`test_is_data`=1) runs second. Each stage issues one single-cycle `test_req` per tap: taps 0 to 31 ascending with edge 0 (rising), then taps 0 to 31 with edge 1 (falling). While a request is out, the stage's edge and delay outputs show the tap under test.
- R2: The reply is taken only while a request is waiting. `test_pass`=1 marks that tap as passing in the current edge's map. The tap advances only on a `test_ack` strobe. A `test_ack` while idle changes no output.
- R3: The window selector scans the taps upward for runs of consecutive passing taps. It keeps the longest run, and the earliest run wins when two runs have the same length. The scan stops early once a run of 8 or more ends while the kept run starts below tap 4. The chosen tap is len/3 when the kept run starts at tap 0. Otherwise it is start + len/2, modulo 32.
- R4: For the command line, the rising edge is chosen when its window length is at least the falling window length. Ties therefore go to rising.
- R5: For the data lines, the rising edge is chosen when its window length is 10 or more, or when it is at least the falling length. The read and write edge outputs always carry the same value.
- R6: A stage fails when both of its maps are empty. The stage's edge output is then rising (0) and its delay output is 31 (all ones). A command failure ends the run with status 1, issues no data requests and leaves the data outputs unchanged. A data failure ends with status 2. Success ends with status 0.
- R7: `busy` is high from the cycle after an accepted start until the run ends. `done` is a one-cycle pulse in the cycle where `busy` falls. A start pulse while busy is ignored.
- R8: After reset, `busy`, `done`, `test_req`, `status` and all edge and delay outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a tuning run when idle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| status | output | 2 | 0 ok, 1 command fail, 2 data fail |
| test_req | output | 1 | Request one test transaction |
| test_is_data | output | 1 | 0 command line under test, 1 data lines |
| test_ack | input | 1 | Test reply strobe |
| test_pass | input | 1 | Test result, valid with test_ack |
| cmd_edge | output | 1 | Command sample edge, 0 rising, 1 falling |
| cmd_dly | output | 5 | Command pad delay tap |
| dat_rd_edge | output | 1 | Data read sample edge |
| dat_wr_edge | output | 1 | Data write sample edge |
| dat_dly | output | 5 | Data pad delay tap |

## Verification
The checker watches these properties on every cycle:
- the request strobe is a single-cycle pulse that only appears while busy;
- `done` is a single-cycle pulse that coincides with the fall of `busy`;
- the status code is one of the three legal values;
- the read and write data edges agree at completion.

Other behaviours only show up in the bench's scenarios:
- the tap and edge order of the sweeps;
- the window choice, including the early-stop scan and the tie and threshold preferences;
- the skipped data stage after a command failure.

The bench checks these by replaying pass maps it drives through the reply handshake.

// File: rtl/tune_seq.sv
module tune_seq #(
  parameter int TAPS            = 32,
  parameter int DATA_RISE_MIN   = 10,
  parameter int EARLY_LEN       = 8,
  parameter int EARLY_START     = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  output logic                     busy,
  output logic                     done,
  output logic [1:0]               status,
  output logic                     test_req,
  output logic                     test_is_data,
  input  logic                     test_ack,
  input  logic                     test_pass,
  output logic                     cmd_edge,
  output logic [$clog2(TAPS)-1:0]  cmd_dly,
  output logic                     dat_rd_edge,
  output logic                     dat_wr_edge,
  output logic [$clog2(TAPS)-1:0]  dat_dly
);
  localparam int DW = $clog2(TAPS);
  localparam int LW = DW + 1;
  localparam logic [LW-1:0] RMIN = LW'(DATA_RISE_MIN);
  localparam logic [LW-1:0] ELEN = LW'(EARLY_LEN);
  localparam logic [DW-1:0] ESTA = DW'(EARLY_START);
  localparam logic [DW-1:0] LAST = DW'(TAPS - 1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_PICK} st_t;

  st_t            st;
  logic           data_stg, edge_q;
  logic [DW-1:0]  tap_q;
  logic [TAPS-1:0] map_r, map_f;
  logic           done_q, drd_q, dwr_q, cedge_q;
  logic [1:0]     status_q;
  logic [DW-1:0]  cdly_q, ddly_q;

  function automatic logic [LW+DW-1:0] pick(input logic [TAPS-1:0] m);
    logic [TAPS:0]  mx;
    logic [LW-1:0]  run, bl, ph;
    logic [DW-1:0]  rs, bs;
    logic           stop;
    mx = {1'b0, m};
    run = '0; bl = '0; rs = '0; bs = '0; stop = 1'b0;
    for (int i = 0; i <= TAPS; i++) begin
      if (!stop) begin
        if (mx[i]) begin
          if (run == '0) rs = i[DW-1:0];
          run = run + 1'b1;
        end else if (run != '0) begin
          if (bl < run) begin
            bl = run;
            bs = rs;
          end
          if (run >= ELEN && bs < ESTA) stop = 1'b1;
          run = '0;
        end
      end
    end
    ph = (bs == '0) ? bl / LW'(3) : ({1'b0, bs} + (bl >> 1));
    return {bl, ph[DW-1:0]};
  endfunction

  logic [LW-1:0] len_r, len_f;
  logic [DW-1:0] tp_r, tp_f;
  always_comb begin
    {len_r, tp_r} = pick(map_r);
    {len_f, tp_f} = pick(map_f);
  end

  wire           rise_sel = data_stg ? (len_r >= RMIN || len_r >= len_f) : (len_r >= len_f);
  wire           sel_fail = rise_sel ? (map_r == '0) : (map_f == '0);
  wire [DW-1:0]  sel_tap  = sel_fail ? '1 : (rise_sel ? tp_r : tp_f);
  wire           sel_edge = ~rise_sel;
  wire           last_tap = (tap_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      data_stg <= 1'b0;
      edge_q <= 1'b0;
      tap_q <= '0;
      map_r <= '0;
      map_f <= '0;
      done_q <= 1'b0;
      status_q <= 2'd0;
      cedge_q <= 1'b0;
      cdly_q <= '0;
      drd_q <= 1'b0;
      dwr_q <= 1'b0;
      ddly_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_ISSUE;
          data_stg <= 1'b0;
          edge_q <= 1'b0;
          tap_q <= '0;
          map_r <= '0;
          map_f <= '0;
          cedge_q <= 1'b0;
          cdly_q <= '0;
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (test_ack) begin
          if (edge_q) map_f[tap_q] <= test_pass;
          else        map_r[tap_q] <= test_pass;
          if (last_tap && edge_q) begin
            st <= S_PICK;
          end else begin
            st <= S_ISSUE;
            edge_q <= edge_q | last_tap;
            tap_q <= last_tap ? '0 : tap_q + 1'b1;
            if (data_stg) begin
              drd_q <= edge_q | last_tap;
              dwr_q <= edge_q | last_tap;
              ddly_q <= last_tap ? '0 : tap_q + 1'b1;
            end else begin
              cedge_q <= edge_q | last_tap;
              cdly_q <= last_tap ? '0 : tap_q + 1'b1;
            end
          end
        end
        S_PICK: begin
          if (data_stg) begin
            drd_q <= sel_edge;
            dwr_q <= sel_edge;
            ddly_q <= sel_tap;
          end else begin
            cedge_q <= sel_edge;
            cdly_q <= sel_tap;
          end
          if (sel_fail || data_stg) begin
            st <= S_IDLE;
            done_q <= 1'b1;
            status_q <= sel_fail ? (data_stg ? 2'd2 : 2'd1) : 2'd0;
          end else begin
            st <= S_ISSUE;
            data_stg <= 1'b1;
            edge_q <= 1'b0;
            tap_q <= '0;
            map_r <= '0;
            map_f <= '0;
            drd_q <= 1'b0;
            dwr_q <= 1'b0;
            ddly_q <= '0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy         = (st != S_IDLE);
  assign done         = done_q;
  assign status       = status_q;
  assign test_req     = (st == S_ISSUE);
  assign test_is_data = data_stg;
  assign cmd_edge     = cedge_q;
  assign cmd_dly      = cdly_q;
  assign dat_rd_edge  = drd_q;
  assign dat_wr_edge  = dwr_q;
  assign dat_dly      = ddly_q;
endmodule

// File: rtl/tune_seq_chk.sv
module tune_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic [1:0] status,
  input logic       test_req,
  input logic       dat_rd_edge,
  input logic       dat_wr_edge
);
  a_r1_req_single: assert property (@(posedge clk) disable iff (!rst_n) test_req |=> !test_req)
    else $error("R1 test_req longer than one cycle");
  a_r1_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n) test_req |-> busy)
    else $error("R1 test_req while idle");
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done)
    else $error("R7 done longer than one cycle");
  a_r7_busy_fall_done: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done)
    else $error("R7 busy fell without done");
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy)
    else $error("R7 done while busy");
  a_r6_status_legal: assert property (@(posedge clk) disable iff (!rst_n) done |-> status != 2'd3)
    else $error("R6 illegal status");
  a_r5_edges_match: assert property (@(posedge clk) disable iff (!rst_n) done |-> dat_rd_edge == dat_wr_edge)
    else $error("R5 read and write edges differ");
endmodule

bind tune_seq tune_seq_chk u_chk (.*);

// File: tb/tune_seq_tb.sv
`timescale 1ns/1ps
module tune_seq_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, start, test_ack, test_pass;
  logic busy, done, test_req, test_is_data, cmd_edge, dat_rd_edge, dat_wr_edge;
  logic [1:0] status;
  logic [4:0] cmd_dly, dat_dly;

  tune_seq u_dut (.*);

  int checks = 0, fails = 0;
  int nreq = 0, order_err = 0;
  logic [31:0] m_cr, m_cf, m_dr, m_df;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void bpick(input logic [31:0] m, output int len, output int ph);
    int s = 0, l, sf = 0, lf = 0;
    if (m == 0) begin len = 0; ph = 255; return; end
    while (s < 32) begin
      l = 0;
      while (s + l < 32 && m[s + l]) l++;
      if (lf < l) begin sf = s; lf = l; end
      s += (l != 0) ? l : 1;
      if (l >= 8 && sf < 4) break;
    end
    len = lf;
    ph = (sf == 0) ? (lf / 3) % 32 : (sf + lf / 2) % 32;
  endfunction

  // responder: answers each request from the model maps, checks sweep order (R1)
  initial begin
    test_ack = 0; test_pass = 0;
    forever begin
      if (!test_req) @(negedge clk);
      else begin
        int stg, e, t, lat;
        logic [31:0] mm;
        stg = nreq / 64; e = (nreq / 32) % 2; t = nreq % 32;
        if (test_is_data !== stg[0]) order_err++;
        if (stg == 0 && (cmd_edge !== e[0] || cmd_dly !== t[4:0])) order_err++;
        if (stg == 1 && (dat_rd_edge !== e[0] || dat_dly !== t[4:0])) order_err++;
        mm = stg == 0 ? (e ? m_cf : m_cr) : (e ? m_df : m_dr);
        nreq++;
        lat = $urandom % 3;
        @(negedge clk);
        repeat (lat) @(negedge clk);
        test_ack = 1; test_pass = mm[t];
        @(negedge clk);
        test_ack = 0; test_pass = 0;
      end
    end
  end

  task automatic run_case(input string nm, input logic [31:0] cr, cf, dr, df);
    int lr, pr, lf, pf, ph, cyc, ldr, pdr, ldf, pdf, exps, expn;
    bit rs;
    logic [4:0] old_dly; logic old_edge;
    m_cr = cr; m_cf = cf; m_dr = dr; m_df = df;
    nreq = 0; order_err = 0;
    old_dly = dat_dly; old_edge = dat_rd_edge;
    start = 1; @(negedge clk); start = 0;
    chk(busy === 1'b1, {"R7 busy after start ", nm}, busy, 1);
    repeat (5) @(negedge clk);
    start = 1; @(negedge clk); start = 0;   // ignored while busy (R7)
    cyc = 0;
    while (done !== 1'b1 && cyc < 20000) begin @(negedge clk); cyc++; end
    chk(cyc < 20000, {"R7 done timeout ", nm}, cyc, 0);
    chk(busy === 1'b0, {"R7 busy low at done ", nm}, busy, 0);
    bpick(cr, lr, pr); bpick(cf, lf, pf);
    rs = lr >= lf;
    ph = rs ? pr : pf;
    chk(cmd_edge === !rs, {"R4 cmd edge ", nm}, cmd_edge, !rs);
    chk(cmd_dly === ph[4:0], {"R3 cmd delay ", nm}, cmd_dly, ph % 32);
    if (ph == 255) begin
      exps = 1; expn = 64;
      chk(dat_dly === old_dly && dat_rd_edge === old_edge, {"R6 data outputs untouched ", nm}, dat_dly, old_dly);
    end else begin
      bpick(dr, ldr, pdr); bpick(df, ldf, pdf);
      rs = (ldr >= 10) || (ldr >= ldf);
      ph = rs ? pdr : pdf;
      exps = (ph == 255) ? 2 : 0; expn = 128;
      chk(dat_rd_edge === !rs, {"R5 data read edge ", nm}, dat_rd_edge, !rs);
      chk(dat_wr_edge === !rs, {"R5 data write edge ", nm}, dat_wr_edge, !rs);
      chk(dat_dly === ph[4:0], {"R3 data delay ", nm}, dat_dly, ph % 32);
    end
    chk(status === exps[1:0], {"R6 status ", nm}, status, exps);
    chk(nreq == expn, {"R1 request count ", nm}, nreq, expn);
    chk(order_err == 0, {"R1 R2 sweep order ", nm}, order_err, 0);
    @(negedge clk);
    chk(done === 1'b0, {"R7 done single cycle ", nm}, done, 0);
  endtask

  function automatic logic [31:0] rmap();
    int s, l; logic [31:0] m;
    if ($urandom % 10 == 0) return 32'h0;
    s = $urandom % 32; l = 1 + $urandom % 32;
    m = (l >= 32) ? 32'hFFFF_FFFF : ((32'h1 << l) - 1);
    m = m << s;
    if ($urandom % 2) m ^= 32'h1 << ($urandom % 32);
    return m;
  endfunction

  initial begin
    int unsigned seed;
    seed = 32'd20251;
    void'($urandom(seed));
    rst_n = 0; start = 0;
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0 && test_req === 0, "R8 reset control", busy, 0);
    chk(cmd_dly === 0 && dat_dly === 0 && status === 0, "R8 reset outputs", cmd_dly, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 0 && test_req === 0, "R8 idle after reset", busy, 0);
    // stray reply while idle (R2)
    test_ack = 1; test_pass = 1; @(negedge clk); test_ack = 0; test_pass = 0;
    @(negedge clk);
    chk(busy === 0 && cmd_dly === 0 && dat_dly === 0, "R2 idle ack ignored", cmd_dly, 0);

    run_case("all pass", '1, '1, '1, '1);
    run_case("cmd empty", 0, 0, '1, '1);
    run_case("data empty", '1, 0, 0, 0);
    run_case("tie and rise10", 32'h0000_FFF0, 32'h0FFF_0000, 32'h3FF0_0000, '1);
    run_case("fall longer", 32'h0000_0FFF, 32'h001F_FFE0, 32'h0000_07FC, 32'h01FF_FFE0);
    run_case("early stop", 32'hFFFF_F1FF, 0, 32'hFFFF_F1FF, 0);
    run_case("rise empty", 0, 32'h00FF_0000, 0, 32'h0000_FF00);
    for (int k = 0; k < 24; k++) run_case($sformatf("random %0d", k), rmap(), rmap(), rmap(), rmap());

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule